// File: doc/BRIEF.md
# Synchronous Burst Flash Read Controller

This controller runs burst reads against a synchronous NOR-style flash. A host issues a command with a start address and a burst-length code. The controller then runs a fixed sequence of phases:

- drive chip select,
- pulse address-valid for one clock,
- enable the memory clock,
- wait a programmable first-access latency,
- capture one word per memory clock,
- keep chip select and output enable asserted for a programmable completion interval.

Each captured word goes back to the host with a valid flag. Write commands are refused with an error pulse and never reach the memory bus.

The memory clock is an enable, `mem_clk_en`, that the clock pad uses to gate the controller clock. Outside the clocked phases the flash sees no edges. Latency, completion hold and burst length are sampled at the clock edge that accepts a command. They then stay fixed for that whole access.

Top module: `sbflash_rd`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_adv_n` and `mem_oe_n` are high, and `mem_clk_en`, `busy`, `ack`, `err` and `rvalid` are low.
- R2: A read request seen while idle is acknowledged by a one-cycle `ack` in the next cycle. `busy` is high from that cycle until the last completion-hold cycle, and it is low in the following cycle.
- R3: `mem_cs_n` goes low in the first cycle after acceptance. `mem_adv_n` is low for exactly the second cycle, so chip select always leads address-valid by one clock. `mem_addr` holds the request address, unchanged, while chip select is low.
- R4: `mem_clk_en` is high from the address-valid cycle through the last burst cycle, and low otherwise.
- R5: The flash data present in the burst cycles is captured as follows. With latency L = `cfg_lat`, the first word appears on `rdata` with `rvalid` high in cycle 4+L after acceptance.
- R6: `req_len` selects the burst size: 0 gives 1 word, 1 gives 4, 2 gives 8 and 3 gives 16. The words arrive on consecutive cycles, in flash order from the start address.
- R7: `mem_oe_n` is low from the cycle after address-valid until the end of the completion hold. The hold lasts H = `cfg_hold` cycles after the last burst cycle, with 0 allowed. `mem_cs_n` and `mem_oe_n` then rise together.
- R8: A request with `req_we` high, of any length, gets `ack` and `err` together for one cycle. It starts no bus cycle: chip select stays high and `busy` stays low.
- R9: A request raised while busy is ignored. `cfg_lat` and `cfg_hold` changes during an access do not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Command request, sampled while idle |
| req_we | input | 1 | Command is a write (refused) |
| req_addr | input | AW | Start address |
| req_len | input | 2 | Burst size code |
| cfg_lat | input | LATW | First-access latency in clocks |
| cfg_hold | input | HOLDW | Completion hold in clocks |
| ack | output | 1 | Command accepted pulse |
| err | output | 1 | Command refused pulse |
| busy | output | 1 | Access in progress |
| rdata | output | DW | Returned word |
| rvalid | output | 1 | `rdata` valid |
| mem_clk_en | output | 1 | Memory clock gate enable |
| mem_addr | output | AW | Flash address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | input | DW | Flash data |

## Verification
The bench uses the default parameters: 24-bit address, 16-bit data, 5-bit latency and 4-bit hold. It sweeps every burst code against latencies 0, 1 and 9 and holds 0, 1 and 3. This covers the shortest possible access, the direct jump from address-valid to burst, and the realistic nine-clock first access. Every output is compared against an arithmetically derived timeline in every cycle of each access. A behavioural flash model serves address-derived words after the latency it recorded at address-valid. This exposes any shift in capture cycle or word order.

// File: rtl/sbflash_rd.sv
module sbflash_rd #(
  parameter int AW    = 24,
  parameter int DW    = 16,
  parameter int LATW  = 5,
  parameter int HOLDW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             req_we,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_len,
  input  logic [LATW-1:0]  cfg_lat,
  input  logic [HOLDW-1:0] cfg_hold,
  output logic             ack,
  output logic             err,
  output logic             busy,
  output logic [DW-1:0]    rdata,
  output logic             rvalid,
  output logic             mem_clk_en,
  output logic [AW-1:0]    mem_addr,
  output logic             mem_cs_n,
  output logic             mem_adv_n,
  output logic             mem_oe_n,
  input  logic [DW-1:0]    mem_dq
);
  localparam int CW0 = (LATW > HOLDW) ? LATW : HOLDW;
  localparam int CW  = (CW0 > 4) ? CW0 : 4;

  typedef enum logic [2:0] {S_IDLE, S_CSU, S_ADV, S_LAT, S_BST, S_HLD} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    blast;
  logic [1:0]       len_q;
  logic [LATW-1:0]  lat_q;
  logic [HOLDW-1:0] hold_q;
  logic [AW-1:0]    addr_q;

  always_comb begin
    case (len_q)
      2'd0:    blast = CW'(0);
      2'd1:    blast = CW'(3);
      2'd2:    blast = CW'(7);
      default: blast = CW'(15);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ack    <= 1'b0;
      err    <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
      addr_q <= '0;
      len_q  <= '0;
      lat_q  <= '0;
      hold_q <= '0;
    end else begin
      ack    <= 1'b0;
      err    <= 1'b0;
      rvalid <= 1'b0;
      case (st)
        S_IDLE: if (req) begin
          ack <= 1'b1;
          if (req_we) err <= 1'b1;
          else begin
            st     <= S_CSU;
            addr_q <= req_addr;
            len_q  <= req_len;
            lat_q  <= cfg_lat;
            hold_q <= cfg_hold;
          end
        end
        S_CSU: st <= S_ADV;
        S_ADV: begin
          if (lat_q == '0) begin
            st  <= S_BST;
            cnt <= blast;
          end else begin
            st  <= S_LAT;
            cnt <= CW'(lat_q) - CW'(1);
          end
        end
        S_LAT: begin
          if (cnt == '0) begin
            st  <= S_BST;
            cnt <= blast;
          end else cnt <= cnt - CW'(1);
        end
        S_BST: begin
          rvalid <= 1'b1;
          rdata  <= mem_dq;
          if (cnt == '0) begin
            if (hold_q == '0) st <= S_IDLE;
            else begin
              st  <= S_HLD;
              cnt <= CW'(hold_q) - CW'(1);
            end
          end else cnt <= cnt - CW'(1);
        end
        S_HLD: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign mem_cs_n   = (st == S_IDLE);
  assign mem_adv_n  = (st != S_ADV);
  assign mem_oe_n   = !(st == S_LAT || st == S_BST || st == S_HLD);
  assign mem_clk_en = (st == S_ADV || st == S_LAT || st == S_BST);
  assign mem_addr   = addr_q;

  // R3
  cs_leads_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> (!mem_cs_n && $past(!mem_cs_n)));
  // R3
  adv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |=> mem_adv_n);
  // R3
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));
  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  // R8
  wr_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ack && mem_cs_n && !busy));
  // R7
  joint_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> $rose(mem_cs_n));
  // R5
  capture_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(mem_clk_en && !mem_oe_n));
endmodule

// File: tb/sbflash_rd_test.sv
module sbflash_rd_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, req_we = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_len = '0;
  logic [4:0]  cfg_lat = '0;
  logic [3:0]  cfg_hold = '0;
  logic        ack, err, busy, rvalid, mem_clk_en, mem_cs_n, mem_adv_n, mem_oe_n;
  logic [15:0] rdata, mem_dq;
  logic [23:0] mem_addr;

  int nchk = 0, nbad = 0;
  int lat_cur = 0, fcnt = 0;
  logic [23:0] fbase = '0;

  always #10 clk = ~clk;

  sbflash_rd uut (.*);

  function automatic logic [15:0] fdata(input logic [23:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8] + a[7:0] + 8'h11};
  endfunction

  always @(posedge clk) if (mem_clk_en) begin
    if (!mem_adv_n) begin fcnt <= 0; fbase <= mem_addr; end
    else fcnt <= fcnt + 1;
  end
  assign mem_dq = (fcnt >= lat_cur) ? fdata(fbase + 24'(fcnt - lat_cur)) : 16'hDEAD;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic run_rd(input logic [23:0] a, input logic [1:0] len, input int L, input int H, input bit poke);
    int n = (len == 0) ? 1 : (2 << len);
    int last = 2 + L + n + H;
    lat_cur = L;
    @(negedge clk);
    req = 1; req_we = 0; req_addr = a; req_len = len;
    cfg_lat = 5'(L); cfg_hold = 4'(H);
    for (int i = 1; i <= last + 2; i++) begin
      @(negedge clk);
      if (i == 1) req = 0;
      if (poke && i == 3) begin
        req = 1; req_addr = ~a; cfg_lat = 5'(L + 3); cfg_hold = 4'(H + 2);
      end
      if (poke && i == 6) begin
        req = 0; cfg_lat = 5'(L); cfg_hold = 4'(H);
      end
      chk(ack == (i == 1), poke ? "R9" : "R2", "ack", ack, i == 1);
      chk(busy == (i <= last), poke ? "R9" : "R2", "busy", busy, i <= last);
      chk(mem_cs_n == !(i <= last), "R3", "cs_n", mem_cs_n, !(i <= last));
      chk(mem_adv_n == (i != 2), "R3", "adv_n", mem_adv_n, i != 2);
      chk(mem_clk_en == (i >= 2 && i <= 2 + L + n), "R4", "clk_en", mem_clk_en, i >= 2 && i <= 2 + L + n);
      chk(mem_oe_n == !(i >= 3 && i <= last), "R7", "oe_n", mem_oe_n, !(i >= 3 && i <= last));
      chk(rvalid == (i >= 4 + L && i <= 3 + L + n), "R5", "rvalid", rvalid, i >= 4 + L && i <= 3 + L + n);
      if (i <= last) chk(mem_addr == a, "R3", "addr", mem_addr, a);
      if (i >= 4 + L && i <= 3 + L + n)
        chk(rdata == fdata(a + 24'(i - 4 - L)), "R6", "rdata", rdata, fdata(a + 24'(i - 4 - L)));
    end
  endtask

  task automatic run_wr(input logic [1:0] len);
    @(negedge clk);
    req = 1; req_we = 1; req_addr = 24'h00ABCD; req_len = len;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 1) begin req = 0; req_we = 0; end
      chk(ack == (i == 1), "R8", "ack", ack, i == 1);
      chk(err == (i == 1), "R8", "err", err, i == 1);
      chk(mem_cs_n == 1'b1, "R8", "cs_n", mem_cs_n, 1);
      chk(busy == 1'b0, "R8", "busy", busy, 0);
      chk(mem_clk_en == 1'b0, "R8", "clk_en", mem_clk_en, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    int lats[3] = '{0, 1, 9};
    int holds[3] = '{0, 1, 3};
    int k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_adv_n && mem_oe_n, "R1", "strobes", {mem_cs_n, mem_adv_n, mem_oe_n}, 3'b111);
    chk(!mem_clk_en && !busy && !ack && !err && !rvalid, "R1", "flags",
        {mem_clk_en, busy, ack, err, rvalid}, 0);
    run_wr(2'd2);
    run_wr(2'd0);
    for (int len = 0; len < 4; len++)
      for (int li = 0; li < 3; li++)
        for (int hi = 0; hi < 3; hi++) begin
          run_rd(24'h01F0F0 + 24'(k * 24'h10B), 2'(len), lats[li], holds[hi],
                 lats[li] == 9 && len >= 1);
          k++;
        end
    run_wr(2'd3);
    run_rd(24'hFFFFF8, 2'd3, 9, 3, 1'b0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule